// File: doc/BRIEF.md
# Test-and-Set Lock Word

This block is a bus slave that holds one 32-bit word and uses it as a hardware mutex shared by several bus masters. A read is a test-and-set: it hands back whatever the word held and, on the same clock edge, leaves the value one in storage. A master that reads zero has taken the lock. A master that reads one must retry. Writing zero releases the lock, and any other written value is stored exactly as given.

The slave sees only its own internal word address, counted from zero, because decoding of the base address happens upstream. The lock word sits at offset zero. Accesses to any other offset in the slave's window are answered but change nothing, and a read there returns zero. The slave accepts one access per cycle, either a read or a write. Every accepted access gets a registered response one cycle later.

Top module: `tas_lock_reg`

## Requirements
- R1: After reset is released the stored word is zero, so the first read at offset zero returns 0x0000_0000, even if a different value was stored before reset.
- R2: A read at offset zero returns, one cycle later on the read-data port, the value stored before that read.
- R3: A read at offset zero leaves the value one (0x0000_0001) stored, whatever was held before, so an immediately following read returns one.
- R4: A write at offset zero stores all 32 bits of the write data unchanged, and the next read returns exactly that value.
- R5: An access at any nonzero word offset leaves the stored word unchanged and, for a read, returns 0x0000_0000.
- R6: The response-valid output is high exactly in the cycle after each cycle with request-valid high, and low otherwise. The read-data output is zero whenever response-valid is low and for the response to a write.
- R7: Two back-to-back reads after reset return zero and then one, and a read that follows a write of zero returns zero again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read (test-and-set) |
| req_addr | input | ADDR_W | Internal word offset, zero-based |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data; zero for writes and idle cycles |

## Verification
If the stored word goes wrong, the error is invisible until the next read at offset zero, and that read shows it on the read-data port one cycle after it is issued. A missing set-to-one therefore shows up as a second read returning zero instead of one. A write that is lost or truncated shows up as the following read returning a value other than the written one. An access at another offset that wrongly touches the word is exposed by the next read at offset zero. A fault in response timing shows on response-valid in the very next cycle.

// File: rtl/tas_pkg.sv
// Package: shared constants for the test-and-set lock word.
// Assumes a 32-bit data path; the value left by a read is fixed at one.
package tas_pkg;
    localparam int unsigned DATA_W = 32;
    typedef logic [DATA_W-1:0] word_t;
    localparam word_t TAKEN_VAL = word_t'(1);
    localparam word_t CLEAR_VAL = '0;

    // Kind of access that hits the lock word this cycle
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_READ = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/tas_decode.sv
// Module: tas_decode
// Classifies the request presented this cycle. Only word offset zero
// reaches the lock word; other offsets are answered but produce OP_NONE.
// Assumes at most one access per cycle (read or write, never both).
module tas_decode #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output tas_pkg::op_e      op,
    output logic              rd_any
);
    import tas_pkg::*;

    logic hit;

    // Offset match against the single word at internal address zero
    always_comb begin
        hit = req_valid && (req_addr == '0);
    end

    // Map the hit and direction to an operation code
    always_comb begin
        if (!hit)          op = OP_NONE;
        else if (req_write) op = OP_WRITE;
        else               op = OP_READ;
        rd_any = req_valid && !req_write;
    end
endmodule

// File: rtl/tas_word.sv
// Module: tas_word
// Holds the lock word. A read sets it to TAKEN_VAL and a write loads the
// data, both on the same edge that accepts the access, so no other access
// can slip between a test and its set. Synchronous active-low reset.
module tas_word (
    input  logic          clk,
    input  logic          rst_n,
    input  tas_pkg::op_e  op,
    input  tas_pkg::word_t wdata,
    output tas_pkg::word_t word_q
);
    import tas_pkg::*;

    word_t word_d;

    // Next-state selection for the stored word
    always_comb begin
        unique case (op)
            OP_READ:  word_d = TAKEN_VAL;
            OP_WRITE: word_d = wdata;
            default:  word_d = word_q;
        endcase
    end

    // Storage register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= CLEAR_VAL;
        else        word_q <= word_d;
    end
endmodule

// File: rtl/tas_resp.sv
// Module: tas_resp
// Registers the response. Valid follows every request by one cycle; data
// carries the pre-access word for a read at offset zero and zero otherwise.
module tas_resp (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  tas_pkg::op_e   op,
    input  tas_pkg::word_t word_q,
    output logic           rsp_valid,
    output tas_pkg::word_t rsp_rdata
);
    import tas_pkg::*;

    word_t data_d;

    // Choose the value returned: old word on a lock read, else zero
    always_comb begin
        data_d = (op == OP_READ) ? word_q : CLEAR_VAL;
    end

    // Response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= CLEAR_VAL;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= data_d;
        end
    end
endmodule

// File: rtl/tas_lock_reg.sv
// Module: tas_lock_reg (top)
// Test-and-set lock word on a simple synchronous slave port. Reads return
// the old word and leave one; writes store the data. The address is the
// zero-based internal word offset; only offset zero holds the word.
module tas_lock_reg #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    import tas_pkg::*;

    op_e   op;
    logic  rd_any;
    word_t word_q;

    tas_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .op        (op),
        .rd_any    (rd_any)
    );

    tas_word u_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .wdata  (req_wdata),
        .word_q (word_q)
    );

    tas_resp u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .op        (op),
        .word_q    (word_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/tas_lock_chk.sv
// Module: tas_lock_chk
// Assertion checker bound to tas_lock_reg. Relates the port requests to
// the stored word and to the registered response.
module tas_lock_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic [31:0]       word_q
);
    logic lock_rd, lock_wr;
    always_comb begin
        lock_rd = req_valid && !req_write && (req_addr == '0);
        lock_wr = req_valid &&  req_write && (req_addr == '0);
    end

    a_r2_read_old_value: assert property (@(posedge clk) disable iff (!rst_n)
        lock_rd |=> rsp_rdata == $past(word_q));
    a_r3_read_sets_one: assert property (@(posedge clk) disable iff (!rst_n)
        lock_rd |=> word_q == 32'd1);
    a_r4_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr |=> word_q == $past(req_wdata));
    a_r5_offset_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr != '0) |=> $stable(word_q));
    a_r5_offset_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr != '0) |=> rsp_rdata == 32'd0);
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_rdata == 32'd0));
    a_r6_write_resp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> rsp_rdata == 32'd0);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> word_q == 32'd0);
endmodule

bind tas_lock_reg tas_lock_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .word_q    (word_q)
);

// File: tb/sim_tas_lock_reg.sv
// Bench for tas_lock_reg: a vector table walked by one loop, then directed
// checks on reset and idle behaviour.
module sim_tas_lock_reg;
    localparam int unsigned ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    tas_lock_reg #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // Vector: write flag, offset, write data, expected read data, requirement
    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0, 32'h0,         32'h0,         4'd1}, // R1 first read 0
        '{1'b0, 4'd0, 32'h0,         32'h1,         4'd7}, // R7 second read 1
        '{1'b1, 4'd0, 32'h0,         32'h0,         4'd6}, // R6 write resp 0
        '{1'b0, 4'd0, 32'h0,         32'h0,         4'd7}, // R7 read after release
        '{1'b1, 4'd0, 32'hA5A5_0F0F, 32'h0,         4'd6}, // R6
        '{1'b0, 4'd0, 32'h0,         32'hA5A5_0F0F, 4'd4}, // R4 full word kept
        '{1'b0, 4'd0, 32'h0,         32'h1,         4'd3}, // R3 set to one
        '{1'b1, 4'd3, 32'h0,         32'h0,         4'd5}, // R5 write elsewhere
        '{1'b0, 4'd3, 32'h0,         32'h0,         4'd5}, // R5 read elsewhere
        '{1'b0, 4'd0, 32'h0,         32'h1,         4'd5}, // R5 word untouched
        '{1'b1, 4'd0, 32'hFFFF_FFFF, 32'h0,         4'd6}, // R6
        '{1'b0, 4'd7, 32'h0,         32'h0,         4'd5}, // R5 no side effect
        '{1'b0, 4'd0, 32'h0,         32'hFFFF_FFFF, 4'd2}, // R2 old value
        '{1'b0, 4'd0, 32'h0,         32'h1,         4'd3}  // R3
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: drive at negedge, sample response at the following negedge
    task automatic access(input logic wr, input logic [3:0] a, input logic [31:0] d,
                          output logic v, output logic [31:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        v = rsp_valid; r = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic v; logic [31:0] r;
        repeat (3) @(negedge clk);
        // R6 reset state: response quiet during reset
        check("R6 reset valid", {31'd0, rsp_valid}, 32'd0);
        check("R6 reset data", rsp_rdata, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, v, r);
            check($sformatf("R6 valid vec %0d", i), {31'd0, v}, 32'd1);
            check($sformatf("R%0d data vec %0d", VECS[i].req, i), r, VECS[i].exp);
        end

        // R6: idle cycle gives no response
        @(negedge clk);
        check("R6 idle valid", {31'd0, rsp_valid}, 32'd0);
        check("R6 idle data", rsp_rdata, 32'd0);

        // R1: reset clears a stored nonzero value
        access(1'b1, 4'd0, 32'h1234_5678, v, r);
        do_reset();
        access(1'b0, 4'd0, 32'h0, v, r);
        check("R1 after reset", r, 32'd0);
        access(1'b0, 4'd0, 32'h0, v, r);
        check("R3 after reset", r, 32'd1);

        // R7: back-to-back reads without gap, then release and re-acquire
        do_reset();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = '0;
        @(negedge clk);
        check("R7 b2b first", rsp_rdata, 32'd0);
        @(negedge clk);
        check("R7 b2b second", rsp_rdata, 32'd1);
        req_write = 1'b1; req_wdata = 32'd0;
        @(negedge clk);
        check("R7 release resp", rsp_rdata, 32'd0);
        req_write = 1'b0;
        @(negedge clk);
        check("R7 reacquire", rsp_rdata, 32'd0);
        req_valid = 1'b0;
        @(negedge clk);
        check("R6 valid drops", {31'd0, rsp_valid}, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule